// File: doc/BRIEF.md
# UART FIFO Request and Transmit-Interrupt Controller

This block sits beside the transmit and receive FIFOs of a UART. It turns their fill levels and a handful of mode-control inputs into three registered request outputs: a transmit interrupt and two DMA request lines, one for receive and one for transmit. It also provides a small line-status output that software can poll when interrupts are turned off. The FIFOs, the serial shifter, the framing logic and the register decode all sit outside the block. They supply its inputs directly.

The DMA mode can be chosen through either of two control paths. A select bit chooses between them. With the select bit low, a single legacy bit chooses between mode 0 and mode 1. With the select bit high, a two-bit extended field chooses any of modes 0 to 3.

- Mode 0 silences both DMA lines.
- Mode 1 drives both lines.
- Mode 2 drives only the receive line.
- Mode 3 drives only the transmit line.

When the FIFOs are enabled, requests follow the programmed thresholds. When the FIFOs are disabled, requests are made one character at a time.

The transmit interrupt has hysteresis. It rises when the transmit FIFO runs empty and falls once the fill level reaches the threshold. It then stays low until the level drains back below the threshold.

Top module: `uart_fifo_req_ctrl`

## Requirements
- R1: With FIFOs enabled and the interrupt enabled, a transmit fill level of 0 sets tx_irq to 1 on the next clock edge, whatever the threshold.
- R2: With FIFOs enabled, a nonzero transmit fill level greater than or equal to tx_thresh clears tx_irq to 0 on the next clock edge.
- R3: With FIFOs enabled and a transmit level strictly between 0 and tx_thresh, tx_irq is set if the level was at or above the threshold at the last edge where it was nonzero. Otherwise it keeps its previous value.
- R4: The effective DMA mode is {1'b0, dma_basic} when mode_src_ext is 0. It is dma_ext_mode (2'd0..2'd3 = modes 0..3) when mode_src_ext is 1, in which case dma_basic has no effect.
- R5: In DMA mode 0, rx_dma_req and tx_dma_req are both 0 after the next edge.
- R6: Mode 1 drives both request lines. Mode 2 drives rx_dma_req only and holds tx_dma_req at 0. Mode 3 drives tx_dma_req only and holds rx_dma_req at 0.
- R7: With FIFOs enabled, the receive condition is rx_level nonzero and rx_level >= rx_thresh. The transmit condition is tx_level < tx_thresh.
- R8: With FIFOs disabled, the receive condition is rx_level != 0 and the transmit condition is tx_level == 0. In this case, and with the interrupt enabled, tx_irq equals (tx_level == 0).
- R9: With tx_irq_en at 0, tx_irq is 0 after the next edge.
- R10: line_status[0] is (rx_level != 0) and line_status[1] is (tx_level == 0), each registered one edge after its inputs.
- R11: While rst_n is low at a clock edge, all outputs go to 0. Every output reflects the inputs present at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_on | input | 1 | FIFO enable; 0 selects single-character operation |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| dma_basic | input | 1 | Legacy DMA mode bit (mode 0 or 1) |
| mode_src_ext | input | 1 | 1 selects the extended mode field as the mode source |
| dma_ext_mode | input | 2 | Extended DMA mode, 0 to 3 |
| tx_thresh | input | CW | Transmit threshold level |
| rx_thresh | input | CW | Receive threshold level |
| tx_level | input | CW | Transmit FIFO occupancy |
| rx_level | input | CW | Receive FIFO occupancy |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| line_status | output | 2 | {transmit empty, receive data present} |

## Verification
The transmit level is moved in a random walk up and down through the threshold. This separates a correct hysteresis from a plain level compare and from an interrupt that never re-arms. Directed sweeps cover every combination of mode_src_ext, dma_basic and dma_ext_mode while both request conditions are true, so a swapped line, a missed legacy path or a leaked dma_basic shows up on the outputs. Single-character cases with the FIFOs off, thresholds of zero and full, and a disabled interrupt separate the two request rules from each other and from the gating.

// File: rtl/uart_req_pkg.sv
// Package: shared types for the UART request controller.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_req_pkg;

    typedef enum logic [1:0] {
        DMA_OFF    = 2'd0,
        DMA_BOTH   = 2'd1,
        DMA_RXONLY = 2'd2,
        DMA_TXONLY = 2'd3
    } dma_mode_e;

endpackage

// File: rtl/uart_dma_mode_dec.sv
// Module: uart_dma_mode_dec
// Picks the effective DMA mode from the legacy bit or the extended field.
// Assumes: inputs are stable around the sampling edge of the consumer.
module uart_dma_mode_dec
    import uart_req_pkg::*;
(
    input  logic       mode_src_ext,
    input  logic       dma_basic,
    input  logic [1:0] dma_ext_mode,
    output dma_mode_e  mode
);

    // Select the mode source; the legacy bit only reaches modes 0 and 1.
    always_comb begin
        if (mode_src_ext) begin
            mode = dma_mode_e'(dma_ext_mode);
        end else begin
            mode = dma_basic ? DMA_BOTH : DMA_OFF;
        end
    end

endmodule

// File: rtl/uart_dma_req_gen.sv
// Module: uart_dma_req_gen
// Registers the RX/TX DMA request lines from FIFO levels and mode.
// Assumes: levels and thresholds share the width CW; synchronous active-low reset.
module uart_dma_req_gen
    import uart_req_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_on,
    input  dma_mode_e     mode,
    input  logic [CW-1:0] tx_thresh,
    input  logic [CW-1:0] rx_thresh,
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_level,
    output logic          rx_dma_req,
    output logic          tx_dma_req
);

    logic rx_cond;
    logic tx_cond;
    logic rx_gate;
    logic tx_gate;

    // Request conditions: threshold based with FIFOs, per character without.
    always_comb begin
        if (fifo_on) begin
            rx_cond = (rx_level != '0) && (rx_level >= rx_thresh);
            tx_cond = (tx_level < tx_thresh);
        end else begin
            rx_cond = (rx_level != '0);
            tx_cond = (tx_level == '0);
        end
    end

    // Mode gating: which of the two lines the current mode may drive.
    always_comb begin
        unique case (mode)
            DMA_OFF:    begin rx_gate = 1'b0; tx_gate = 1'b0; end
            DMA_BOTH:   begin rx_gate = 1'b1; tx_gate = 1'b1; end
            DMA_RXONLY: begin rx_gate = 1'b1; tx_gate = 1'b0; end
            DMA_TXONLY: begin rx_gate = 1'b0; tx_gate = 1'b1; end
            default:    begin rx_gate = 1'b0; tx_gate = 1'b0; end
        endcase
    end

    // Output registers for both request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_dma_req <= 1'b0;
            tx_dma_req <= 1'b0;
        end else begin
            rx_dma_req <= rx_gate & rx_cond;
            tx_dma_req <= tx_gate & tx_cond;
        end
    end

endmodule

// File: rtl/uart_tx_irq_hyst.sv
// Module: uart_tx_irq_hyst
// Transmit interrupt with hysteresis around the TX threshold.
// Assumes: an empty FIFO takes priority over the threshold compare.
module uart_tx_irq_hyst #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_on,
    input  logic          tx_irq_en,
    input  logic [CW-1:0] tx_thresh,
    input  logic [CW-1:0] tx_level,
    output logic          tx_irq
);

    logic st_q;
    logic armed_q;
    logic st_d;
    logic armed_d;

    // Next state: set on empty or on drain below threshold once armed.
    always_comb begin
        st_d    = st_q;
        armed_d = armed_q;
        if (!fifo_on) begin
            st_d    = (tx_level == '0);
            armed_d = 1'b0;
        end else if (tx_level == '0) begin
            st_d    = 1'b1;
            armed_d = 1'b0;
        end else if (tx_level >= tx_thresh) begin
            st_d    = 1'b0;
            armed_d = 1'b1;
        end else if (armed_q) begin
            st_d    = 1'b1;
            armed_d = 1'b0;
        end
    end

    // State and gated output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= 1'b0;
            armed_q <= 1'b0;
            tx_irq  <= 1'b0;
        end else begin
            st_q    <= st_d;
            armed_q <= armed_d;
            tx_irq  <= tx_irq_en & st_d;
        end
    end

endmodule

// File: rtl/uart_fifo_req_ctrl.sv
// Module: uart_fifo_req_ctrl (top)
// Builds the TX interrupt, the RX/TX DMA requests and a polled line status
// from FIFO occupancy, thresholds and the mode-control inputs.
// Assumes: occupancy never exceeds DEPTH; synchronous active-low reset.
module uart_fifo_req_ctrl
    import uart_req_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_on,
    input  logic          tx_irq_en,
    input  logic          dma_basic,
    input  logic          mode_src_ext,
    input  logic [1:0]    dma_ext_mode,
    input  logic [CW-1:0] tx_thresh,
    input  logic [CW-1:0] rx_thresh,
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_level,
    output logic          tx_irq,
    output logic          rx_dma_req,
    output logic          tx_dma_req,
    output logic [1:0]    line_status
);

    dma_mode_e mode;

    uart_dma_mode_dec u_dec (
        .mode_src_ext (mode_src_ext),
        .dma_basic    (dma_basic),
        .dma_ext_mode (dma_ext_mode),
        .mode         (mode)
    );

    uart_dma_req_gen #(.CW(CW)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_on    (fifo_on),
        .mode       (mode),
        .tx_thresh  (tx_thresh),
        .rx_thresh  (rx_thresh),
        .tx_level   (tx_level),
        .rx_level   (rx_level),
        .rx_dma_req (rx_dma_req),
        .tx_dma_req (tx_dma_req)
    );

    uart_tx_irq_hyst #(.CW(CW)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_on   (fifo_on),
        .tx_irq_en (tx_irq_en),
        .tx_thresh (tx_thresh),
        .tx_level  (tx_level),
        .tx_irq    (tx_irq)
    );

    // Polled status register: {tx empty, rx data present}.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_status <= 2'b00;
        end else begin
            line_status <= {(tx_level == '0), (rx_level != '0)};
        end
    end

endmodule

// File: rtl/uart_fifo_req_ctrl_chk.sv
// Module: uart_fifo_req_ctrl_chk
// Port-level temporal checks for uart_fifo_req_ctrl, attached by bind.
// Assumes: synchronous active-low reset; all outputs registered.
module uart_fifo_req_ctrl_chk #(
    parameter int CW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_on,
    input logic          tx_irq_en,
    input logic          dma_basic,
    input logic          mode_src_ext,
    input logic [1:0]    dma_ext_mode,
    input logic [CW-1:0] tx_thresh,
    input logic [CW-1:0] tx_level,
    input logic [CW-1:0] rx_level,
    input logic          tx_irq,
    input logic          rx_dma_req,
    input logic          tx_dma_req,
    input logic [1:0]    line_status
);

    p_empty_sets_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && tx_irq_en && tx_level == '0) |=> tx_irq);

    p_thresh_clears_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && tx_level != '0 && tx_level >= tx_thresh) |=> !tx_irq);

    p_mode0_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_src_ext && dma_ext_mode == 2'd0) || (!mode_src_ext && !dma_basic))
        |=> (!rx_dma_req && !tx_dma_req));

    p_mode2_tx_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_src_ext && dma_ext_mode == 2'd2) |=> !tx_dma_req);

    p_mode3_rx_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_src_ext && dma_ext_mode == 2'd3) |=> !rx_dma_req);

    p_irq_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_irq_en |=> !tx_irq);

    p_status_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |=> !line_status[0]);

endmodule

bind uart_fifo_req_ctrl uart_fifo_req_ctrl_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_on      (fifo_on),
    .tx_irq_en    (tx_irq_en),
    .dma_basic    (dma_basic),
    .mode_src_ext (mode_src_ext),
    .dma_ext_mode (dma_ext_mode),
    .tx_thresh    (tx_thresh),
    .tx_level     (tx_level),
    .rx_level     (rx_level),
    .tx_irq       (tx_irq),
    .rx_dma_req   (rx_dma_req),
    .tx_dma_req   (tx_dma_req),
    .line_status  (line_status)
);

// File: tb/uart_fifo_req_ctrl_bench.sv
// Bench for uart_fifo_req_ctrl: directed corners plus seeded random walk,
// compared against a requirement-level model built from bench functions.
module uart_fifo_req_ctrl_bench;

    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fifo_on, tx_irq_en, dma_basic, mode_src_ext;
    logic [1:0]    dma_ext_mode;
    logic [CW-1:0] tx_thresh, rx_thresh, tx_level, rx_level;
    logic          tx_irq, rx_dma_req, tx_dma_req;
    logic [1:0]    line_status;

    int n_run  = 0;
    int n_fail = 0;
    logic m_st = 1'b0;
    logic m_armed = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    uart_fifo_req_ctrl #(.DEPTH(DEPTH)) u_uart_fifo_req_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .tx_irq_en(tx_irq_en),
        .dma_basic(dma_basic), .mode_src_ext(mode_src_ext),
        .dma_ext_mode(dma_ext_mode), .tx_thresh(tx_thresh),
        .rx_thresh(rx_thresh), .tx_level(tx_level), .rx_level(rx_level),
        .tx_irq(tx_irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .line_status(line_status)
    );

    // Effective mode per R4.
    function automatic logic [1:0] f_mode();
        return mode_src_ext ? dma_ext_mode : {1'b0, dma_basic};
    endfunction

    // RX request per R5..R8.
    function automatic logic f_rx();
        logic [1:0] m = f_mode();
        logic c = fifo_on ? (rx_level != 0 && rx_level >= rx_thresh) : (rx_level != 0);
        return c && (m == 2'd1 || m == 2'd2);
    endfunction

    // TX request per R5..R8.
    function automatic logic f_tx();
        logic [1:0] m = f_mode();
        logic c = fifo_on ? (tx_level < tx_thresh) : (tx_level == 0);
        return c && (m == 2'd1 || m == 2'd3);
    endfunction

    task automatic chk(input string req, input string nm, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, nm, act, exp);
        end
    endtask

    // One clock: model the edge, then compare at the following falling edge.
    task automatic cycle(input string req);
        logic e_rx, e_tx, e_irq;
        logic [1:0] e_ls;
        e_rx = f_rx();
        e_tx = f_tx();
        e_ls = {tx_level == 0, rx_level != 0};
        if (!fifo_on) begin
            m_st = (tx_level == 0); m_armed = 1'b0;
        end else if (tx_level == 0) begin
            m_st = 1'b1; m_armed = 1'b0;
        end else if (tx_level >= tx_thresh) begin
            m_st = 1'b0; m_armed = 1'b1;
        end else if (m_armed) begin
            m_st = 1'b1; m_armed = 1'b0;
        end
        e_irq = tx_irq_en & m_st;
        @(posedge clk);
        @(negedge clk);
        chk(req, "tx_irq", tx_irq, e_irq);
        chk(req, "rx_dma_req", rx_dma_req, e_rx);
        chk(req, "tx_dma_req", tx_dma_req, e_tx);
        chk("R10", "line_status", line_status[0], e_ls[0]);
        chk("R10", "line_status_tx", line_status[1], e_ls[1]);
    endtask

    task automatic set_mode(input logic sel, input logic bas, input logic [1:0] ext);
        mode_src_ext = sel; dma_basic = bas; dma_ext_mode = ext;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; fifo_on = 1'b1; tx_irq_en = 1'b1;
        set_mode(1'b0, 1'b1, 2'd0);
        tx_thresh = 8; rx_thresh = 4; tx_level = 3; rx_level = 9;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "tx_irq", tx_irq, 1'b0);
        chk("R11", "rx_dma_req", rx_dma_req, 1'b0);
        chk("R11", "tx_dma_req", tx_dma_req, 1'b0);
        chk("R11", "line_status", line_status[0], 1'b0);
        rst_n = 1'b1;

        // R3: mid-range level after reset, never armed: interrupt stays low
        cycle("R3");
        // R1 / R2 / R3 hysteresis walk
        tx_level = 0;  cycle("R1");
        tx_level = 5;  cycle("R3");
        tx_level = 8;  cycle("R2");
        tx_level = 12; cycle("R2");
        tx_level = 7;  cycle("R3");
        tx_level = 6;  cycle("R3");
        tx_thresh = 0; tx_level = 0; cycle("R1");
        tx_thresh = 8;

        // R4..R7: all modes with both conditions true
        rx_level = 5; tx_level = 2;
        set_mode(1'b0, 1'b0, 2'd3); cycle("R5");
        set_mode(1'b0, 1'b1, 2'd0); cycle("R6");
        set_mode(1'b1, 1'b1, 2'd0); cycle("R4");
        set_mode(1'b1, 1'b0, 2'd1); cycle("R6");
        set_mode(1'b1, 1'b1, 2'd2); cycle("R6");
        set_mode(1'b1, 1'b0, 2'd3); cycle("R6");
        set_mode(1'b1, 1'b1, 2'd1);
        rx_level = 3; tx_level = 8; cycle("R7");
        rx_level = 4; tx_level = 7; cycle("R7");
        rx_thresh = 0; rx_level = 0; cycle("R7");
        rx_thresh = 4;

        // R8: single-character operation
        fifo_on = 1'b0;
        rx_level = 1; tx_level = 0; cycle("R8");
        rx_level = 0; tx_level = 1; cycle("R8");
        fifo_on = 1'b1;

        // R9: interrupt disabled
        tx_irq_en = 1'b0; tx_level = 0; cycle("R9");
        tx_irq_en = 1'b1;

        // Random walk mixed with mode and threshold changes
        for (int i = 0; i < 4000; i++) begin
            int d;
            if ($urandom_range(15) == 0)
                set_mode(1'($urandom), 1'($urandom), 2'($urandom));
            if ($urandom_range(31) == 0) tx_thresh = CW'($urandom_range(DEPTH));
            if ($urandom_range(31) == 0) rx_thresh = CW'($urandom_range(DEPTH));
            if ($urandom_range(63) == 0) fifo_on = ~fifo_on;
            if ($urandom_range(63) == 0) tx_irq_en = ~tx_irq_en;
            d = int'($urandom_range(4)) - 2;
            if (int'(tx_level) + d >= 0 && int'(tx_level) + d <= DEPTH) tx_level = CW'(int'(tx_level) + d);
            d = int'($urandom_range(4)) - 2;
            if (int'(rx_level) + d >= 0 && int'(rx_level) + d <= DEPTH) rx_level = CW'(int'(rx_level) + d);
            cycle("R3");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule